// File: doc/BRIEF.md
# Strobed Three-Port Parallel Interface

This block gives a processor three byte-wide parallel ports, called A, B and C, behind a small register window. A two-bit address picks one of the three port data registers or a write-only control register. When the control word has its top bit set, it configures the port modes. When that bit is clear, it sets or clears one bit of the port C output latch.

Each of ports A and B can run in one of three ways. In basic mode it is a plain latched output or an unlatched input. In strobed mode it is a one-byte input or output buffer with a handshake. Port A can also run as a bidirectional strobed bus. In the strobed modes, some port C pins stop being general I/O and become the buffer-full, strobe, acknowledge and interrupt lines of the handshake. The interrupt-enable bits sit in the port C latch at the positions of the strobe and acknowledge pins, so software sets them with the single-bit command.

The pins are sampled on the block clock. A handshake edge is recognised on the first clock edge that sees the new pin level.

Top module: `strobed_pio`

## Requirements
- R1: Address 00 selects port A data, 01 selects port B data, 10 selects port C data and 11 selects the control register. A read of the control address returns zero.
- R2: A control write with bit 7 = 1 loads the mode. Bits 6:5 set the port A mode: 00 basic, 01 strobed, 1x bidirectional. Bit 4 = 1 makes port A an input and bit 3 = 1 makes port C bits 7:4 inputs. Bit 2 = 1 puts port B in strobed mode, bit 1 = 1 makes port B an input and bit 0 = 1 makes port C bits 3:0 inputs. After reset every port is a basic-mode input, so no output enable is on. Word 0x80 makes every port an output.
- R3: A control write with bit 7 = 0 writes bit 0 into the port C latch bit selected by bits 3:1. Bits 6:4 are ignored and the other latch bits keep their values.
- R4: In basic mode a written output value is held and driven with every enable bit on, and a read returns that held value. A basic-mode input read returns the live pins. Word 0x98 gives A input, B output, C upper input and C lower output.
- R5: A mode write clears the A, B and C output latches, both buffer-full flags and all pending interrupts. The output-full line (active low) goes high.
- R6: For a strobed input, a falling strobe (PC4 for A, PC2 for B) captures the port pins and raises the input-full line (PC5 for A, PC1 for B). A read of the port returns the captured byte and clears the flag.
- R7: For a strobed input, the interrupt line (PC3 for A, PC0 for B) goes high when the strobe returns high with the buffer full, but only while the enable latch bit (PC4 for A, PC2 for B) is 1. A read of the port clears it.
- R8: For a strobed output, a CPU write to the port drives the output-full line (PC7 for A, PC1 for B) low. A low acknowledge (PC6 for A, PC2 for B) drives it high again.
- R9: For a strobed output, a rising acknowledge with the buffer empty raises the interrupt line (PC3 for A, PC0 for B) while the enable latch bit (PC6 for A, PC2 for B) is 1. The next write to the port clears it.
- R10: In bidirectional mode, port A drives its pins only while PC6 is low, and all eight bits switch together. Input and output handshakes on A both run, and the PC3 interrupt is the OR of the two.
- R11: A port C read returns the status at handshake output positions and the enable latch bits at strobe and acknowledge positions. A general bit returns its latch when it is an output and its pin when it is an input.
- R12: A port C handshake output is always driven and a handshake input is never driven. The other bits follow their group direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | 2 | Register select |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for the current address |
| pa_i | input | DW | Port A pins in |
| pa_o | output | DW | Port A pins out |
| pa_oe_o | output | DW | Port A output enables |
| pb_i | input | DW | Port B pins in |
| pb_o | output | DW | Port B pins out |
| pb_oe_o | output | DW | Port B output enables |
| pc_i | input | DW | Port C pins in |
| pc_o | output | DW | Port C pins out |
| pc_oe_o | output | DW | Port C output enables |

## Verification
The assertions check these rules on every cycle:
- a mode write clears the latches;
- a single-bit command changes at most one port C latch bit;
- a strobe fall raises input-full and a write drops output-full on the next cycle;
- a low acknowledge empties the output buffer;
- the bidirectional drivers switch all together.

Some behaviour needs a sequence of accesses, so only the bench scenarios show it. This covers:
- the interrupt gating by the enable bits;
- the clearing of interrupts by the matching read or write;
- the port C status layout in each mode;
- the fact that a captured byte survives later pin changes;
- the sweeps over every data value and every port C bit.

// File: rtl/spio_pkg.sv
package spio_pkg;

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } spio_sel_e;

  // Field order matches control word bits 6:0
  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } spio_cfg_t;

  localparam spio_cfg_t CFG_RST = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                    b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  // Port C roles in strobed modes
  localparam int PC_IRQ_B  = 0;
  localparam int PC_FULL_B = 1;
  localparam int PC_STB_B  = 2;
  localparam int PC_IRQ_A  = 3;
  localparam int PC_STB_A  = 4;
  localparam int PC_FULL_A = 5;
  localparam int PC_ACK_A  = 6;
  localparam int PC_OFN_A  = 7;

endpackage

// File: rtl/spio_cfg.sv
module spio_cfg
  import spio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ctl_i,
  input  logic          wr_pc_i,
  input  logic [DW-1:0] wdata_i,
  output spio_cfg_t     cfg_o,
  output logic [DW-1:0] pc_q_o,
  output logic          mode_wr_o
);
  localparam int BW = $clog2(DW);

  logic bit_wr;

  assign mode_wr_o = wr_ctl_i & wdata_i[DW-1];
  assign bit_wr    = wr_ctl_i & ~wdata_i[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= CFG_RST;
      pc_q_o <= '0;
    end else if (mode_wr_o) begin
      cfg_o  <= spio_cfg_t'(wdata_i[6:0]);
      pc_q_o <= '0;
    end else if (bit_wr) begin
      pc_q_o[wdata_i[BW:1]] <= wdata_i[0];
    end else if (wr_pc_i) begin
      pc_q_o <= wdata_i;
    end
  end

endmodule

// File: rtl/spio_hs.sv
module spio_hs #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          in_en_i,
  input  logic          out_en_i,
  input  logic          stb_ni,
  input  logic          ack_ni,
  input  logic [DW-1:0] din_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] in_q_o,
  output logic [DW-1:0] out_q_o,
  output logic          in_full_o,
  output logic          out_full_no,
  output logic          in_pend_o,
  output logic          out_pend_o
);
  logic stb_q, ack_q;
  logic stb_fall, stb_rise, ack_rise;

  assign stb_fall = in_en_i & stb_q & ~stb_ni;
  assign stb_rise = in_en_i & ~stb_q & stb_ni;
  assign ack_rise = out_en_i & ~ack_q & ack_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b1;
      ack_q <= 1'b1;
    end else begin
      stb_q <= stb_ni;
      ack_q <= ack_ni;
    end
  end

  // input side: capture on strobe fall, set beats read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q_o    <= '0;
      in_full_o <= 1'b0;
      in_pend_o <= 1'b0;
    end else if (clr_i) begin
      in_q_o    <= '0;
      in_full_o <= 1'b0;
      in_pend_o <= 1'b0;
    end else begin
      if (stb_fall) begin
        in_q_o    <= din_i;
        in_full_o <= 1'b1;
      end else if (rd_i) begin
        in_full_o <= 1'b0;
      end
      if (stb_rise && in_full_o) in_pend_o <= 1'b1;
      else if (rd_i)             in_pend_o <= 1'b0;
    end
  end

  // output side: write fills, ack low empties, ack rise flags done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q_o     <= '0;
      out_full_no <= 1'b1;
      out_pend_o  <= 1'b0;
    end else if (clr_i) begin
      out_q_o     <= '0;
      out_full_no <= 1'b1;
      out_pend_o  <= 1'b0;
    end else begin
      if (wr_i) out_q_o <= wdata_i;
      if (wr_i && out_en_i)          out_full_no <= 1'b0;
      else if (out_en_i && !ack_ni)  out_full_no <= 1'b1;
      if (wr_i)                          out_pend_o <= 1'b0;
      else if (ack_rise && out_full_no)  out_pend_o <= 1'b1;
    end
  end

endmodule

// File: rtl/strobed_pio.sv
module strobed_pio
  import spio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe_o,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe_o
);
  localparam int HW = DW / 2;

  spio_sel_e      sel;
  spio_cfg_t      cfg;
  logic [DW-1:0]  pc_q;
  logic           mode_wr;
  logic           wr_a, wr_b, wr_c, wr_ctl, rd_a, rd_b;
  logic           a_m1, a_m2, b_m1;
  logic           a_hs_in, a_hs_out, b_hs_in, b_hs_out;
  logic [DW-1:0]  a_in_q, a_out_q, b_in_q, b_out_q;
  logic           a_full, a_ofn, a_ipend, a_opend;
  logic           b_full, b_ofn, b_ipend, b_opend;
  logic           irq_a, irq_b;
  logic [DW-1:0]  hs_out_m, hs_in_m, hs_val, gen_oe, pc_rd, pa_rd, pb_rd;

  assign sel    = spio_sel_e'(addr_i);
  assign wr_a   = cs_i & wr_i & (sel == SEL_A);
  assign wr_b   = cs_i & wr_i & (sel == SEL_B);
  assign wr_c   = cs_i & wr_i & (sel == SEL_C);
  assign wr_ctl = cs_i & wr_i & (sel == SEL_CTL);
  assign rd_a   = cs_i & rd_i & (sel == SEL_A);
  assign rd_b   = cs_i & rd_i & (sel == SEL_B);

  spio_cfg #(.DW(DW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_ctl_i (wr_ctl),
    .wr_pc_i  (wr_c),
    .wdata_i  (wdata_i),
    .cfg_o    (cfg),
    .pc_q_o   (pc_q),
    .mode_wr_o(mode_wr)
  );

  assign a_m2     = cfg.a_mode[1];
  assign a_m1     = (cfg.a_mode == 2'b01);
  assign b_m1     = cfg.b_mode;
  assign a_hs_in  = a_m2 | (a_m1 & cfg.a_in);
  assign a_hs_out = a_m2 | (a_m1 & ~cfg.a_in);
  assign b_hs_in  = b_m1 & cfg.b_in;
  assign b_hs_out = b_m1 & ~cfg.b_in;

  spio_hs #(.DW(DW)) u_hs_a (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (mode_wr),
    .in_en_i    (a_hs_in),
    .out_en_i   (a_hs_out),
    .stb_ni     (pc_i[PC_STB_A]),
    .ack_ni     (pc_i[PC_ACK_A]),
    .din_i      (pa_i),
    .rd_i       (rd_a),
    .wr_i       (wr_a),
    .wdata_i    (wdata_i),
    .in_q_o     (a_in_q),
    .out_q_o    (a_out_q),
    .in_full_o  (a_full),
    .out_full_no(a_ofn),
    .in_pend_o  (a_ipend),
    .out_pend_o (a_opend)
  );

  // B uses one pin as strobe or ack depending on direction
  spio_hs #(.DW(DW)) u_hs_b (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (mode_wr),
    .in_en_i    (b_hs_in),
    .out_en_i   (b_hs_out),
    .stb_ni     (pc_i[PC_STB_B]),
    .ack_ni     (pc_i[PC_STB_B]),
    .din_i      (pb_i),
    .rd_i       (rd_b),
    .wr_i       (wr_b),
    .wdata_i    (wdata_i),
    .in_q_o     (b_in_q),
    .out_q_o    (b_out_q),
    .in_full_o  (b_full),
    .out_full_no(b_ofn),
    .in_pend_o  (b_ipend),
    .out_pend_o (b_opend)
  );

  // enables live in the port C latch at strobe/ack positions
  assign irq_a = (a_hs_in  & a_ipend & pc_q[PC_STB_A]) |
                 (a_hs_out & a_opend & pc_q[PC_ACK_A]);
  assign irq_b = b_m1 & (b_hs_in ? b_ipend : b_opend) & pc_q[PC_STB_B];

  always_comb begin
    hs_out_m = '0;
    hs_in_m  = '0;
    hs_val   = '0;
    if (a_hs_in) begin
      hs_out_m[PC_IRQ_A]  = 1'b1;
      hs_out_m[PC_FULL_A] = 1'b1;
      hs_in_m[PC_STB_A]   = 1'b1;
      hs_val[PC_FULL_A]   = a_full;
    end
    if (a_hs_out) begin
      hs_out_m[PC_IRQ_A] = 1'b1;
      hs_out_m[PC_OFN_A] = 1'b1;
      hs_in_m[PC_ACK_A]  = 1'b1;
      hs_val[PC_OFN_A]   = a_ofn;
    end
    hs_val[PC_IRQ_A] = irq_a;
    if (b_m1) begin
      hs_out_m[PC_IRQ_B]  = 1'b1;
      hs_out_m[PC_FULL_B] = 1'b1;
      hs_in_m[PC_STB_B]   = 1'b1;
      hs_val[PC_IRQ_B]    = irq_b;
      hs_val[PC_FULL_B]   = cfg.b_in ? b_full : b_ofn;
    end
  end

  assign gen_oe  = {{(DW-HW){~cfg.cu_in}}, {HW{~cfg.cl_in}}};
  assign pc_oe_o = (gen_oe | hs_out_m) & ~hs_in_m;
  assign pc_o    = (pc_q & ~hs_out_m) | (hs_val & hs_out_m);

  generate
    for (genvar i = 0; i < DW; i++) begin : g_pc_rd
      assign pc_rd[i] = hs_out_m[i] ? hs_val[i] :
                        hs_in_m[i]  ? pc_q[i]   :
                        gen_oe[i]   ? pc_q[i]   : pc_i[i];
    end
  endgenerate

  assign pa_o    = a_out_q;
  assign pa_oe_o = a_m2 ? {DW{~pc_i[PC_ACK_A]}} : {DW{~cfg.a_in}};
  assign pa_rd   = a_hs_in ? a_in_q : (cfg.a_in ? pa_i : a_out_q);

  assign pb_o    = b_out_q;
  assign pb_oe_o = {DW{~cfg.b_in}};
  assign pb_rd   = b_hs_in ? b_in_q : (cfg.b_in ? pb_i : b_out_q);

  always_comb begin
    unique case (sel)
      SEL_A:   rdata_o = pa_rd;
      SEL_B:   rdata_o = pb_rd;
      SEL_C:   rdata_o = pc_rd;
      default: rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/strobed_pio_chk.sv
module strobed_pio_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_i,
  input logic          wr_i,
  input logic [1:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] pc_i,
  input logic [DW-1:0] pc_o,
  input logic [DW-1:0] pc_oe_o,
  input logic [DW-1:0] pa_o,
  input logic [DW-1:0] pb_o,
  input logic [DW-1:0] pa_oe_o,
  input logic [DW-1:0] pc_q,
  input logic          a_hs_in,
  input logic          a_hs_out
);
  logic ctl_wr, mode_wr, any_wr;
  assign any_wr  = cs_i & wr_i;
  assign ctl_wr  = any_wr & (addr_i == 2'b11);
  assign mode_wr = ctl_wr & wdata_i[DW-1];

  p_mode_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> (pa_o == '0 && pb_o == '0 && pc_q == '0));

  p_bit_cmd_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && !wdata_i[DW-1]) |=> ($countones(pc_q ^ $past(pc_q)) <= 1));

  p_strobe_fills_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_hs_in && $fell(pc_i[4]) && !mode_wr) |=> pc_o[5]);

  p_write_fills_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_hs_out && any_wr && addr_i == 2'b00) |=> !pc_o[7]);

  p_ack_empties_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_hs_out && !pc_i[6] && !any_wr) |=> pc_o[7]);

  p_bus_drive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pa_oe_o == '0) || (pa_oe_o == '1));

  p_hs_in_undriven_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_hs_in |-> !pc_oe_o[4]);

endmodule

bind strobed_pio strobed_pio_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .pc_i    (pc_i),
  .pc_o    (pc_o),
  .pc_oe_o (pc_oe_o),
  .pa_o    (pa_o),
  .pb_o    (pb_o),
  .pa_oe_o (pa_oe_o),
  .pc_q    (pc_q),
  .a_hs_in (a_hs_in),
  .a_hs_out(a_hs_out)
);

// File: tb/sim_strobed_pio.sv
module sim_strobed_pio;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       cs, rd, wr;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] pa_i, pa_o, pa_oe, pb_i, pb_o, pb_oe, pc_i, pc_o, pc_oe;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  strobed_pio #(.DW(8)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic pulse_c(input int bit_i);
    @(negedge clk); pc_i[bit_i] = 1'b0;
    @(negedge clk); pc_i[bit_i] = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp;
    rst_ni = 1'b0; cs = 0; rd = 0; wr = 0; addr = 0; wdata = 0;
    pa_i = 8'h3C; pb_i = 8'hC3; pc_i = 8'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 reset state: all inputs
    chk("R2 reset pa_oe", pa_oe, 8'h00);
    chk("R2 reset pb_oe", pb_oe, 8'h00);
    chk("R2 reset pc_oe", pc_oe, 8'h00);
    // R1 address decode
    cpu_rd(2'b00, d); chk("R1 read A", d, 8'h3C);
    cpu_rd(2'b01, d); chk("R1 read B", d, 8'hC3);
    cpu_rd(2'b10, d); chk("R1 R11 read C pins", d, 8'hFF);
    cpu_rd(2'b11, d); chk("R1 read ctl", d, 8'h00);

    // R2 R4 all outputs, sweep every value
    cpu_wr(2'b11, 8'h80);
    chk("R2 out pa_oe", pa_oe, 8'hFF);
    chk("R2 out pb_oe", pb_oe, 8'hFF);
    chk("R2 out pc_oe", pc_oe, 8'hFF);
    for (int v = 0; v < 256; v++) begin
      cpu_wr(2'b00, 8'(v));
      cpu_wr(2'b01, ~8'(v));
      chk("R4 pa_o", pa_o, 8'(v));
      chk("R4 pb_o", pb_o, ~8'(v));
      cpu_rd(2'b00, d); chk("R4 A readback", d, 8'(v));
    end

    // R3 bit set/reset sweep
    cpu_wr(2'b10, 8'h00);
    exp = 8'h00;
    for (int i = 0; i < 8; i++) begin
      cpu_wr(2'b11, {4'b0000, 3'(i), 1'b1});
      exp = exp | (8'h01 << i);
      chk("R3 set", pc_o, exp);
    end
    for (int i = 0; i < 8; i++) begin
      cpu_wr(2'b11, {4'b0111, 3'(i), 1'b0});
      exp = exp & ~(8'h01 << i);
      chk("R3 clear", pc_o, exp);
    end
    cpu_wr(2'b11, 8'h7B);
    chk("R3 ignored bits", pc_o, 8'h20);

    // R5 mode write clears latches
    cpu_wr(2'b00, 8'h5A); cpu_wr(2'b01, 8'hA5); cpu_wr(2'b10, 8'hFF);
    cpu_wr(2'b11, 8'h80);
    chk("R5 pa_o", pa_o, 8'h00);
    chk("R5 pb_o", pb_o, 8'h00);
    chk("R5 pc_o", pc_o, 8'h00);

    // R4 mixed basic mode 0x98
    cpu_wr(2'b11, 8'h98);
    chk("R4 98 pa_oe", pa_oe, 8'h00);
    chk("R4 98 pb_oe", pb_oe, 8'hFF);
    chk("R12 98 pc_oe", pc_oe, 8'h0F);
    for (int v = 0; v < 256; v += 5) begin
      pa_i = 8'(v);
      cpu_rd(2'b00, d); chk("R4 live A", d, 8'(v));
    end
    pc_i = 8'hA5;
    cpu_wr(2'b10, 8'h0C);
    cpu_rd(2'b10, d); chk("R11 mixed C", d, 8'hAC);
    chk("R4 pc latch", pc_o, 8'h0C);
    pc_i = 8'hFF;

    // R6 R7 strobed input on A
    cpu_wr(2'b11, 8'hB0);
    chk("R12 strobed-in pc_oe", pc_oe, 8'hEF);
    cpu_wr(2'b11, 8'h09);
    pa_i = 8'h3C;
    @(negedge clk); pc_i[4] = 1'b0;
    @(negedge clk);
    chk("R6 full set", {7'b0, pc_o[5]}, 8'h01);
    pa_i = 8'h00; pc_i[4] = 1'b1;
    @(negedge clk);
    chk("R7 irq set", {7'b0, pc_o[3]}, 8'h01);
    cpu_rd(2'b10, d); chk("R11 status C", d, 8'h38);
    cpu_rd(2'b00, d); chk("R6 captured byte", d, 8'h3C);
    chk("R6 full cleared", {7'b0, pc_o[5]}, 8'h00);
    chk("R7 irq cleared", {7'b0, pc_o[3]}, 8'h00);
    cpu_wr(2'b11, 8'h08);
    pa_i = 8'h11;
    pulse_c(4);
    chk("R6 full no-ie", {7'b0, pc_o[5]}, 8'h01);
    chk("R7 irq masked", {7'b0, pc_o[3]}, 8'h00);
    cpu_rd(2'b00, d); chk("R6 second byte", d, 8'h11);

    // R8 R9 strobed output on B
    cpu_wr(2'b11, 8'h84);
    cpu_wr(2'b11, 8'h05);
    cpu_wr(2'b01, 8'h77);
    chk("R8 pb_o", pb_o, 8'h77);
    chk("R8 full low", {7'b0, pc_o[1]}, 8'h00);
    @(negedge clk); pc_i[2] = 1'b0;
    @(negedge clk);
    chk("R8 ack empties", {7'b0, pc_o[1]}, 8'h01);
    chk("R9 no irq yet", {7'b0, pc_o[0]}, 8'h00);
    pc_i[2] = 1'b1;
    @(negedge clk);
    chk("R9 irq on ack", {7'b0, pc_o[0]}, 8'h01);
    cpu_wr(2'b01, 8'h78);
    chk("R9 write clears irq", {7'b0, pc_o[0]}, 8'h00);
    chk("R8 full again", {7'b0, pc_o[1]}, 8'h00);

    // R10 bidirectional A
    cpu_wr(2'b11, 8'hC0);
    chk("R10 idle no drive", pa_oe, 8'h00);
    @(negedge clk); pc_i[6] = 1'b0;
    #1 chk("R10 drive on ack", pa_oe, 8'hFF);
    pc_i[6] = 1'b1;
    #1 chk("R10 release", pa_oe, 8'h00);
    cpu_wr(2'b11, 8'h09);
    cpu_wr(2'b00, 8'h99);
    chk("R10 R8 full low", {7'b0, pc_o[7]}, 8'h00);
    pulse_c(6);
    chk("R10 R8 emptied", {7'b0, pc_o[7]}, 8'h01);
    chk("R10 R9 out irq masked", {7'b0, pc_o[3]}, 8'h00);
    pa_i = 8'hA5;
    pulse_c(4);
    chk("R10 R6 in full", {7'b0, pc_o[5]}, 8'h01);
    chk("R10 R7 in irq", {7'b0, pc_o[3]}, 8'h01);
    cpu_rd(2'b00, d); chk("R10 in byte", d, 8'hA5);
    chk("R10 out latch kept", pa_o, 8'h99);
    cpu_wr(2'b11, 8'h0D);
    cpu_wr(2'b00, 8'h42);
    chk("R10 R9 write clears", {7'b0, pc_o[3]}, 8'h00);
    pulse_c(6);
    chk("R10 R9 out irq", {7'b0, pc_o[3]}, 8'h01);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule